// File: doc/BRIEF.md
# DMA/HDMA Bus Takeover Arbiter

This block decides when the general-purpose DMA engine and the per-scanline HDMA engine take over the CPU bus, and in what order. Requests come from a general DMA request, a frame-start HDMA init trigger and a per-line HDMA run trigger. When a request is pending, the arbiter claims the bus. It serves HDMA first and then general DMA. Each transfer start is aligned to the 8-clock DMA phase. On exit, the bus is returned with a stall that realigns the CPU to its own cycle length.

The arbiter does not move data. It pulses a start strobe to the external HDMA or DMA engine and waits for that engine's done pulse. It reports each stall it needs as a length on a one-cycle strobe, and it tells the clock counter when to clear. A small interrupt-poll stage sits beside it. An interrupt lock holds back NMI and IRQ sampling until the next clock advance. This models the delay after events such as a DMA end.

Top module: `bus_xfer_arb`

## Requirements
- R1: While idle with any request pending, `clr_clks_o` pulses for one cycle and `active_o` is high from the next cycle. It stays high until the sequence ends.
- R2: A pulse on `hdma_init_trig_i` makes HDMA pending with `hdma_mode_o`=0 (init), but only if `hdma_en_i` is nonzero. A pulse on `hdma_line_trig_i` makes HDMA pending with `hdma_mode_o`=1 (run), but only if `hdma_act_i` is nonzero.
- R3: When HDMA and general DMA are both pending, `hdma_start_o` pulses before `dma_start_o`. At most one of `clr_clks_o`, `hdma_start_o` and `dma_start_o` is high in any cycle.
- R4: A served HDMA with `dma_en_i`=0 first emits a stall of 8 − `phase_i` clocks, in the cycle before `hdma_start_o`.
- R5: A served HDMA with `dma_en_i` nonzero emits no alignment stall. When the engine reports done, there is no resync stall, and the arbiter goes on to the general DMA check.
- R6: A pending general DMA with `dma_en_i` nonzero emits a stall of 8 − `phase_i`, then `dma_start_o` in the next cycle. On `xfer_done_i` it emits a stall of `cpu_cyc_i` − (`dma_clks_i` mod `cpu_cyc_i`), and `active_o` drops in the next cycle.
- R7: When HDMA is done with `dma_en_i`=0, it emits the same resync stall as R6, and `active_o` drops in the next cycle.
- R8: A pending request is cleared when it is examined. If its channel mask is zero at that moment, it is dropped with no start strobe. If no general DMA follows, `active_o` falls with no resync stall.
- R9: `lock_set_i` sets the interrupt lock and `adv_i` clears it. If both are high, set wins.
- R10: `poll_i` with the lock clear ORs `nmi_i` and `irq_i` into the pending flags. With the lock set, the flags are unchanged by polling. `nmi_ack_i` and `irq_ack_i` clear their flags, but a poll in the same cycle wins.
- R11: `int_pend_o` is high exactly when `nmi_pend_o` or `irq_pend_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dma_req_i | input | 1 | General DMA request pulse |
| hdma_init_trig_i | input | 1 | Frame-start HDMA init trigger |
| hdma_line_trig_i | input | 1 | Per-line HDMA run trigger |
| hdma_en_i | input | NCH | HDMA channel enable mask |
| hdma_act_i | input | NCH | HDMA channels still active this frame |
| dma_en_i | input | NCH | General DMA channel enable mask |
| phase_i | input | 3 | Current 8-clock DMA phase |
| cpu_cyc_i | input | CYC_W | CPU cycle length in clocks (nonzero) |
| dma_clks_i | input | CLK_W | Clocks elapsed since the takeover began |
| xfer_done_i | input | 1 | Transfer engine finished its run |
| adv_i | input | 1 | Clock advance (clears interrupt lock) |
| lock_set_i | input | 1 | Set interrupt lock |
| poll_i | input | 1 | Interrupt sample point |
| nmi_i | input | 1 | NMI test result |
| irq_i | input | 1 | IRQ test result |
| nmi_ack_i | input | 1 | Clear pending NMI |
| irq_ack_i | input | 1 | Clear pending IRQ |
| active_o | output | 1 | Bus held by DMA/HDMA |
| hdma_mode_o | output | 1 | 0 = init, 1 = run |
| clr_clks_o | output | 1 | Clear the DMA clock counter |
| stall_vld_o | output | 1 | Stall request strobe |
| stall_len_o | output | CYC_W | Stall length in clocks |
| hdma_start_o | output | 1 | Start HDMA engine |
| dma_start_o | output | 1 | Start general DMA engine |
| nmi_pend_o | output | 1 | NMI pending |
| irq_pend_o | output | 1 | IRQ pending |
| int_pend_o | output | 1 | Any interrupt pending |

## Verification
The assertions assume that `cpu_cyc_i` is never zero and that `xfer_done_i` arrives only after a start strobe, while the arbiter waits for its engine. The bench keeps to both conditions. Its engine model raises done a fixed number of cycles after each observed start, and its cycle lengths are taken from 6, 8 and 12. The channel masks and the phase change only between scenarios, except in the drop case. There, the HDMA enable is deliberately withdrawn while the request is pending.

// File: rtl/bxa_pkg.sv
package bxa_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_HCHK, S_HSTART, S_HWAIT, S_DCHK, S_DSTART, S_DWAIT
  } arb_st_e;

  typedef enum logic {
    HMODE_INIT = 1'b0,
    HMODE_RUN  = 1'b1
  } hdma_mode_e;
endpackage

// File: rtl/bxa_pend.sv
module bxa_pend
  import bxa_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dma_req_i,
  input  logic init_trig_i,
  input  logic line_trig_i,
  input  logic hen_any_i,
  input  logic hact_any_i,
  input  logic hclr_i,
  input  logic dclr_i,
  output logic hpend_o,
  output logic dpend_o,
  output logic mode_o
);
  logic       hset, dset;
  hdma_mode_e mode_q;

  assign hset = (init_trig_i && hen_any_i) || (line_trig_i && hact_any_i);
  assign dset = dma_req_i;

  // set beats clear: a fresh request survives its own service cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hpend_o <= 1'b0;
      dpend_o <= 1'b0;
      mode_q  <= HMODE_INIT;
    end else begin
      if (hset)        hpend_o <= 1'b1;
      else if (hclr_i) hpend_o <= 1'b0;
      if (dset)        dpend_o <= 1'b1;
      else if (dclr_i) dpend_o <= 1'b0;
      if (line_trig_i && hact_any_i)     mode_q <= HMODE_RUN;
      else if (init_trig_i && hen_any_i) mode_q <= HMODE_INIT;
    end
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/bxa_seq.sv
module bxa_seq
  import bxa_pkg::*;
#(
  parameter int CYC_W = 4,
  parameter int CLK_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hpend_i,
  input  logic             dpend_i,
  input  logic             hen_any_i,
  input  logic             den_any_i,
  input  logic             done_i,
  input  logic [2:0]       phase_i,
  input  logic [CYC_W-1:0] cyc_i,
  input  logic [CLK_W-1:0] clks_i,
  output logic             hclr_o,
  output logic             dclr_o,
  output logic             clr_clks_o,
  output logic             stall_vld_o,
  output logic [CYC_W-1:0] stall_len_o,
  output logic             hstart_o,
  output logic             dstart_o,
  output logic             active_o
);
  arb_st_e st_q, st_d;
  logic [CYC_W-1:0] align_len, resync_len;
  logic [CLK_W-1:0] cyc_ext, rem;

  assign align_len  = CYC_W'(4'd8 - {1'b0, phase_i});
  assign cyc_ext    = CLK_W'(cyc_i);
  assign rem        = clks_i % cyc_ext;
  assign resync_len = cyc_i - CYC_W'(rem);

  always_comb begin
    st_d        = st_q;
    hclr_o      = 1'b0;
    dclr_o      = 1'b0;
    clr_clks_o  = 1'b0;
    stall_vld_o = 1'b0;
    stall_len_o = '0;
    unique case (st_q)
      S_IDLE: if (hpend_i || dpend_i) begin
        clr_clks_o = 1'b1;
        st_d       = S_HCHK;
      end
      S_HCHK: begin
        st_d = S_DCHK;
        if (hpend_i) begin
          hclr_o = 1'b1;
          if (hen_any_i) begin
            st_d = S_HSTART;
            if (!den_any_i) begin
              stall_vld_o = 1'b1;
              stall_len_o = align_len;
            end
          end
        end
      end
      S_HSTART: st_d = S_HWAIT;
      S_HWAIT: if (done_i) begin
        if (den_any_i) st_d = S_DCHK;
        else begin
          stall_vld_o = 1'b1;
          stall_len_o = resync_len;
          st_d        = S_IDLE;
        end
      end
      S_DCHK: begin
        dclr_o = dpend_i;
        st_d   = S_IDLE;
        if (dpend_i && den_any_i) begin
          stall_vld_o = 1'b1;
          stall_len_o = align_len;
          st_d        = S_DSTART;
        end
      end
      S_DSTART: st_d = S_DWAIT;
      S_DWAIT: if (done_i) begin
        stall_vld_o = 1'b1;
        stall_len_o = resync_len;
        st_d        = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= S_IDLE;
    else         st_q <= st_d;
  end

  assign hstart_o = (st_q == S_HSTART);
  assign dstart_o = (st_q == S_DSTART);
  assign active_o = (st_q != S_IDLE);
endmodule

// File: rtl/bxa_irq.sv
module bxa_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  input  logic lock_set_i,
  input  logic poll_i,
  input  logic nmi_i,
  input  logic irq_i,
  input  logic nmi_ack_i,
  input  logic irq_ack_i,
  output logic nmi_pend_o,
  output logic irq_pend_o
);
  logic lock_q, sample;

  assign sample = poll_i && !lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q     <= 1'b0;
      nmi_pend_o <= 1'b0;
      irq_pend_o <= 1'b0;
    end else begin
      if (lock_set_i) lock_q <= 1'b1;
      else if (adv_i) lock_q <= 1'b0;
      if (sample && nmi_i)  nmi_pend_o <= 1'b1;
      else if (nmi_ack_i)   nmi_pend_o <= 1'b0;
      if (sample && irq_i)  irq_pend_o <= 1'b1;
      else if (irq_ack_i)   irq_pend_o <= 1'b0;
    end
  end
endmodule

// File: rtl/bus_xfer_arb.sv
module bus_xfer_arb #(
  parameter int NCH   = 8,
  parameter int CYC_W = 4,
  parameter int CLK_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dma_req_i,
  input  logic             hdma_init_trig_i,
  input  logic             hdma_line_trig_i,
  input  logic [NCH-1:0]   hdma_en_i,
  input  logic [NCH-1:0]   hdma_act_i,
  input  logic [NCH-1:0]   dma_en_i,
  input  logic [2:0]       phase_i,
  input  logic [CYC_W-1:0] cpu_cyc_i,
  input  logic [CLK_W-1:0] dma_clks_i,
  input  logic             xfer_done_i,
  input  logic             adv_i,
  input  logic             lock_set_i,
  input  logic             poll_i,
  input  logic             nmi_i,
  input  logic             irq_i,
  input  logic             nmi_ack_i,
  input  logic             irq_ack_i,
  output logic             active_o,
  output logic             hdma_mode_o,
  output logic             clr_clks_o,
  output logic             stall_vld_o,
  output logic [CYC_W-1:0] stall_len_o,
  output logic             hdma_start_o,
  output logic             dma_start_o,
  output logic             nmi_pend_o,
  output logic             irq_pend_o,
  output logic             int_pend_o
);
  logic hen_any, hact_any, den_any;
  logic hpend, dpend, hclr, dclr;

  assign hen_any  = |hdma_en_i;
  assign hact_any = |hdma_act_i;
  assign den_any  = |dma_en_i;

  bxa_pend u_pend (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .dma_req_i   (dma_req_i),
    .init_trig_i (hdma_init_trig_i),
    .line_trig_i (hdma_line_trig_i),
    .hen_any_i   (hen_any),
    .hact_any_i  (hact_any),
    .hclr_i      (hclr),
    .dclr_i      (dclr),
    .hpend_o     (hpend),
    .dpend_o     (dpend),
    .mode_o      (hdma_mode_o)
  );

  bxa_seq #(.CYC_W(CYC_W), .CLK_W(CLK_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hpend_i     (hpend),
    .dpend_i     (dpend),
    .hen_any_i   (hen_any),
    .den_any_i   (den_any),
    .done_i      (xfer_done_i),
    .phase_i     (phase_i),
    .cyc_i       (cpu_cyc_i),
    .clks_i      (dma_clks_i),
    .hclr_o      (hclr),
    .dclr_o      (dclr),
    .clr_clks_o  (clr_clks_o),
    .stall_vld_o (stall_vld_o),
    .stall_len_o (stall_len_o),
    .hstart_o    (hdma_start_o),
    .dstart_o    (dma_start_o),
    .active_o    (active_o)
  );

  bxa_irq u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .adv_i      (adv_i),
    .lock_set_i (lock_set_i),
    .poll_i     (poll_i),
    .nmi_i      (nmi_i),
    .irq_i      (irq_i),
    .nmi_ack_i  (nmi_ack_i),
    .irq_ack_i  (irq_ack_i),
    .nmi_pend_o (nmi_pend_o),
    .irq_pend_o (irq_pend_o)
  );

  assign int_pend_o = nmi_pend_o | irq_pend_o;
endmodule

// File: rtl/bxa_chk.sv
module bxa_chk #(
  parameter int CYC_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             hdma_init_trig_i,
  input logic             hdma_line_trig_i,
  input logic             poll_i,
  input logic             nmi_i,
  input logic             active_o,
  input logic             hdma_mode_o,
  input logic             clr_clks_o,
  input logic             stall_vld_o,
  input logic [CYC_W-1:0] stall_len_o,
  input logic             hdma_start_o,
  input logic             dma_start_o,
  input logic             nmi_pend_o
);
  p_clr_then_active_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_clks_o |=> active_o);

  p_mode_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hdma_init_trig_i || hdma_line_trig_i) |=> $stable(hdma_mode_o));

  p_start_onehot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({clr_clks_o, hdma_start_o, dma_start_o}));

  p_stall_nonzero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_vld_o |-> stall_len_o != '0);

  p_dma_aligned_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dma_start_o) |-> $past(stall_vld_o));

  p_start_active_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hdma_start_o || dma_start_o) |-> active_o);

  p_nmi_rise_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(nmi_pend_o) |-> $past(poll_i && nmi_i));
endmodule

bind bus_xfer_arb bxa_chk #(.CYC_W(CYC_W)) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .hdma_init_trig_i (hdma_init_trig_i),
  .hdma_line_trig_i (hdma_line_trig_i),
  .poll_i           (poll_i),
  .nmi_i            (nmi_i),
  .active_o         (active_o),
  .hdma_mode_o      (hdma_mode_o),
  .clr_clks_o       (clr_clks_o),
  .stall_vld_o      (stall_vld_o),
  .stall_len_o      (stall_len_o),
  .hdma_start_o     (hdma_start_o),
  .dma_start_o      (dma_start_o),
  .nmi_pend_o       (nmi_pend_o)
);

// File: tb/bus_xfer_arb_tb.sv
`timescale 1ns/1ps
module bus_xfer_arb_tb;
  localparam int NCH = 8, CYC_W = 4, CLK_W = 16;

  logic clk = 0, rst_n = 0;
  logic dma_req = 0, init_trig = 0, line_trig = 0;
  logic [NCH-1:0] hen = 0, hact = 0, den = 0;
  logic [2:0] phase = 0;
  logic [CYC_W-1:0] cyc = 4'd6;
  logic [CLK_W-1:0] clks = 0;
  logic done = 0, adv = 0, lock_set = 0, poll = 0, nmi = 0, irq = 0, nack = 0, iack = 0;
  logic active, mode, clr, sv, hs, ds, np, ip, intp;
  logic [CYC_W-1:0] sl;

  int n_tests = 0, n_fail = 0;
  string scen = "reset";
  bit finished = 0;

  always #10 clk = ~clk;

  bus_xfer_arb #(.NCH(NCH), .CYC_W(CYC_W), .CLK_W(CLK_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .dma_req_i(dma_req), .hdma_init_trig_i(init_trig),
    .hdma_line_trig_i(line_trig), .hdma_en_i(hen), .hdma_act_i(hact), .dma_en_i(den),
    .phase_i(phase), .cpu_cyc_i(cyc), .dma_clks_i(clks), .xfer_done_i(done),
    .adv_i(adv), .lock_set_i(lock_set), .poll_i(poll), .nmi_i(nmi), .irq_i(irq),
    .nmi_ack_i(nack), .irq_ack_i(iack), .active_o(active), .hdma_mode_o(mode),
    .clr_clks_o(clr), .stall_vld_o(sv), .stall_len_o(sl), .hdma_start_o(hs),
    .dma_start_o(ds), .nmi_pend_o(np), .irq_pend_o(ip), .int_pend_o(intp));

  // reference model: 0 idle,1 hdma check,2 hdma start,3 hdma wait,4 dma check,5 dma start,6 dma wait
  int m_st; bit m_hp, m_dp, m_mode, m_lock, m_nmi, m_irq;

  function automatic int align_len(); return 8 - int'(phase); endfunction
  function automatic int resync_len(); return int'(cyc) - (int'(clks) % int'(cyc)); endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_hp = 0; m_dp = 0; m_mode = 0; m_lock = 0; m_nmi = 0; m_irq = 0;
    end else begin
      int nst; bit hs_set, nhp, ndp;
      nst = m_st; nhp = m_hp; ndp = m_dp;
      if (m_st == 0) begin if (m_hp || m_dp) nst = 1; end
      else if (m_st == 1) begin
        if (m_hp) nhp = 0;
        nst = (m_hp && hen != 0) ? 2 : 4;
      end
      else if (m_st == 2) nst = 3;
      else if (m_st == 3) begin if (done) nst = (den != 0) ? 4 : 0; end
      else if (m_st == 4) begin
        if (m_dp) ndp = 0;
        nst = (m_dp && den != 0) ? 5 : 0;
      end
      else if (m_st == 5) nst = 6;
      else if (m_st == 6) begin if (done) nst = 0; end
      hs_set = (init_trig && hen != 0) || (line_trig && hact != 0);
      if (hs_set) nhp = 1;
      if (dma_req) ndp = 1;
      if (line_trig && hact != 0) m_mode = 1;
      else if (init_trig && hen != 0) m_mode = 0;
      if (poll && !m_lock) begin
        if (nmi) m_nmi = 1; else if (nack) m_nmi = 0;
        if (irq) m_irq = 1; else if (iack) m_irq = 0;
      end else begin
        if (nack) m_nmi = 0;
        if (iack) m_irq = 0;
      end
      if (lock_set) m_lock = 1; else if (adv) m_lock = 0;
      m_st = nst; m_hp = nhp; m_dp = ndp;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s [%s] %s act=%0d exp=%0d t=%0t", req, scen, what, act, exp, $time);
    end
  endtask

  // compare every cycle, after the negedge drivers have settled
  always @(negedge clk) begin
    #2;
    if (!finished) begin
      int e_sv, e_sl;
      e_sv = 0; e_sl = 0;
      if (m_st == 1 && m_hp && hen != 0 && den == 0) begin e_sv = 1; e_sl = align_len(); end
      if (m_st == 3 && done && den == 0) begin e_sv = 1; e_sl = resync_len(); end
      if (m_st == 4 && m_dp && den != 0) begin e_sv = 1; e_sl = align_len(); end
      if (m_st == 6 && done) begin e_sv = 1; e_sl = resync_len(); end
      chk("R1", "active", int'(active), int'(m_st != 0));
      chk("R1", "clr_clks", int'(clr), int'(m_st == 0 && (m_hp || m_dp)));
      chk("R2", "mode", int'(mode), int'(m_mode));
      chk("R3", "hdma_start", int'(hs), int'(m_st == 2));
      chk("R6", "dma_start", int'(ds), int'(m_st == 5));
      chk("R4", "stall_vld", int'(sv), e_sv);
      if (e_sv != 0) chk("R6", "stall_len", int'(sl), e_sl);
      chk("R10", "nmi_pend", int'(np), int'(m_nmi));
      chk("R10", "irq_pend", int'(ip), int'(m_irq));
      chk("R11", "int_pend", int'(intp), int'(m_nmi || m_irq));
    end
  end

  // transfer engine stand-in: done 3 cycles after a start
  int eng_cnt = 0;
  always @(negedge clk) begin
    done <= 1'b0;
    if (eng_cnt > 0) begin
      eng_cnt--;
      if (eng_cnt == 0) done <= 1'b1;
    end
    if (hs || ds) eng_cnt = 3;
  end

  task automatic step(input int n); repeat (n) @(negedge clk); endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  int hs_seen, ds_seen, order_ok;
  always @(negedge clk) begin
    if (hs) hs_seen++;
    if (ds) begin ds_seen++; if (hs_seen == 0) order_ok = 0; end
  end

  initial begin
    step(3);
    chk("R1", "reset active", int'(active), 0);
    rst_n = 1;
    step(2);

    // R2: init trigger with no HDMA enabled is ignored
    scen = "R2 init-no-en";
    init_trig = 1; step(1); init_trig = 0; step(6);
    chk("R2", "no takeover", int'(active), 0);

    // R2: line trigger with no active channel is ignored
    scen = "R2 line-no-act";
    hen = 8'h01; line_trig = 1; step(1); line_trig = 0; step(6);
    chk("R2", "no takeover", int'(active), 0);

    // R4/R7: HDMA init alone, phase 3, cycle 6
    scen = "R4 R7 hdma-only";
    hen = 8'h04; den = 0; phase = 3'd3; cyc = 4'd6; clks = 16'd13;
    init_trig = 1; step(1); init_trig = 0; step(14);
    chk("R7", "idle after", int'(active), 0);

    // R3/R5/R6: HDMA run plus general DMA together
    scen = "R3 R5 R6 both";
    hen = 8'h01; hact = 8'h01; den = 8'h03; phase = 3'd5; cyc = 4'd8; clks = 16'd21;
    hs_seen = 0; ds_seen = 0; order_ok = 1;
    line_trig = 1; dma_req = 1; step(1); line_trig = 0; dma_req = 0; step(20);
    chk("R3", "hdma before dma", order_ok + hs_seen + ds_seen, 3);

    // R6: general DMA alone across cycle lengths and counts
    hen = 0; hact = 0; den = 8'h80;
    for (int c = 0; c < 3; c++) begin
      for (int k = 0; k < 4; k++) begin
        scen = "R6 dma-only";
        cyc = (c == 0) ? 4'd6 : (c == 1) ? 4'd8 : 4'd12;
        phase = 3'(k * 3);
        clks = 16'(k * 7 + c * 5);
        dma_req = 1; step(1); dma_req = 0; step(12);
      end
    end

    // R8: DMA request with no enabled channel is dropped
    scen = "R8 dma-drop";
    den = 0; hs_seen = 0; ds_seen = 0;
    dma_req = 1; step(1); dma_req = 0; step(8);
    chk("R8", "no start", ds_seen, 0);
    chk("R8", "released", int'(active), 0);

    // R8: HDMA enable withdrawn while pending
    scen = "R8 hdma-drop";
    hen = 8'h10; hs_seen = 0;
    init_trig = 1; step(1); init_trig = 0; hen = 0; step(8);
    chk("R8", "no hdma start", hs_seen, 0);

    // R9/R10: lock and poll
    scen = "R9 R10 irq";
    poll = 1; nmi = 1; step(1); poll = 0; nmi = 0; step(1);
    chk("R10", "nmi taken", int'(np), 1);
    nack = 1; step(1); nack = 0; step(1);
    lock_set = 1; step(1); lock_set = 0;
    poll = 1; irq = 1; step(1); poll = 0; irq = 0; step(1);
    chk("R9", "locked poll ignored", int'(ip), 0);
    lock_set = 1; adv = 1; step(1); lock_set = 0; adv = 0;
    poll = 1; irq = 1; step(1); poll = 0; irq = 0; step(1);
    chk("R9", "set wins over advance", int'(ip), 0);
    adv = 1; step(1); adv = 0;
    poll = 1; irq = 1; iack = 1; step(1); poll = 0; irq = 0; iack = 0; step(1);
    chk("R10", "poll beats ack", int'(ip), 1);
    iack = 1; step(1); iack = 0; step(2);
    chk("R11", "all clear", int'(intp), 0);

    finish_run();
  end
endmodule